// File: doc/BRIEF.md
# Stack Push Unit

This block executes one already-decoded push. On an accepted start it takes the current stack pointer and lowers it by the operand width: two bytes for a 16-bit operand, four for a 32-bit one. It then issues one memory write of the operand at the lowered pointer. When the write is acknowledged it returns the new stack pointer value with a one-cycle completion strobe. The operand width and the stack width are separate inputs. A 16-bit stack moves only the low half of the pointer and wraps within it. A 32-bit stack moves the whole pointer. Neither choice forces the other.

The operand is a supplied value, the stack pointer itself, or a segment selector. For the stack pointer, the value written is the one held before the push. For a memory source whose address uses the stack pointer as base, the block also forms the operand address from the pre-push pointer. In real mode, a push that finds the pointer equal to 1 does not write. Instead it raises a sticky shutdown output and raises no exception. Nothing here reads or changes processor flags, and there is no alignment check.

Top module: `stack_push_unit`

## Requirements
- R1: After reset, wr_valid, done, busy and shutdown are 0 and sp_out is 0.
- R2: With op_wide=1 and stk_wide=1, the new pointer is sp_in minus 4, and wr_addr equals that new pointer.
- R3: A 32-bit operand writes with wr_be=4'b1111. A 16-bit operand writes with wr_be=4'b0011, its value in wr_data[15:0] and zeros above, and lowers the pointer by 2.
- R4: With stk_wide=0, only bits [15:0] of the pointer change, modulo 65536, and bits [31:16] are kept. wr_addr is the new 16-bit pointer, zero-extended.
- R5: src_kind=1 (stack pointer) writes sp_in as it was before the push, truncated to the operand width.
- R6: src_kind=2 (segment selector) writes src_val[15:0]. With a 32-bit operand, bits [31:16] are zero. src_kind=0 or 3 writes src_val.
- R7: On an accepted start, ea_addr becomes (ea_use_sp ? sp_in : ea_base) + ea_disp, using the pointer before the decrement.
- R8: wr_valid stays high, with wr_addr, wr_data and wr_be unchanged, until wr_ready is sampled high. done is high for exactly the one cycle after that handshake, and sp_out holds the new pointer from then on.
- R9: In real mode, a start that finds the active pointer equal to 1 sets shutdown. The active pointer is SP when stk_wide=0 and the full ESP when stk_wide=1. No write and no done follow, sp_out is unchanged, and shutdown holds until reset.
- R10: A 16-bit push on a 32-bit stack may leave the pointer not a multiple of 4, and the push completes normally.
- R11: A start while busy is 1 is ignored.
- R12: Outside real mode, or in real mode when the active pointer is not 1, a pointer of 1 wraps like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a push; taken only when busy is 0 |
| sp_in | input | 32 | Current stack pointer |
| src_kind | input | 2 | Operand source: 0 value, 1 stack pointer, 2 segment selector, 3 value |
| src_val | input | 32 | Operand value or selector |
| op_wide | input | 1 | Operand size: 1 = 32-bit, 0 = 16-bit |
| stk_wide | input | 1 | Stack address size: 1 = 32-bit, 0 = 16-bit |
| real_mode | input | 1 | Processor is in real mode |
| ea_use_sp | input | 1 | Memory operand uses the stack pointer as base |
| ea_base | input | 32 | Base register value when not the stack pointer |
| ea_disp | input | 32 | Operand address displacement |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Write byte address (the new top of stack) |
| wr_data | output | 32 | Write data, right-aligned |
| wr_be | output | 4 | Write byte enables |
| ea_addr | output | 32 | Memory operand address latched at start |
| sp_out | output | 32 | Updated stack pointer |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | A push is in progress, or the unit is shut down |
| shutdown | output | 1 | Sticky real-mode stack exhaustion |

## Verification
The assertions assume the write channel is polite. The memory may hold wr_ready low for any time, and the source inputs only matter in the cycle start is accepted. The stimulus changes inputs only at the falling edge. It holds wr_ready low for several cycles in one case, and it raises start while a write is pending so that the ignored start is visible at the ports. The vector table covers both operand widths against both stack widths, the stack pointer and selector sources, and wrap at the 16-bit boundary. Directed cases cover the real-mode pointer-equals-one rule, in both stack widths, and its release by reset.

// File: rtl/spu_pkg.sv
package spu_pkg;
  typedef enum logic [1:0] {
    SRC_VALUE    = 2'd0,
    SRC_STACKPTR = 2'd1,
    SRC_SEGSEL   = 2'd2,
    SRC_ALTVAL   = 2'd3
  } src_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_HALT  = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/spu_sp_calc.sv
module spu_sp_calc #(
  parameter int SP_W     = 32,
  parameter int NARROW_W = 16
) (
  input  logic [SP_W-1:0] sp_cur,
  input  logic            op_wide,
  input  logic            stk_wide,
  output logic [SP_W-1:0] sp_next,
  output logic [SP_W-1:0] sp_addr,
  output logic            sp_at_one
);
  localparam int WIDE_STEP   = SP_W / 8;
  localparam int NARROW_STEP = NARROW_W / 8;
  localparam int HI_W        = SP_W - NARROW_W;

  logic [SP_W-1:0]     step;
  logic [SP_W-1:0]     wide_next;
  logic [NARROW_W-1:0] low_next;

  always_comb begin
    step      = op_wide ? SP_W'(WIDE_STEP) : SP_W'(NARROW_STEP);
    wide_next = sp_cur - step;
    low_next  = sp_cur[NARROW_W-1:0] - step[NARROW_W-1:0];
    if (stk_wide) begin
      sp_next   = wide_next;
      sp_addr   = wide_next;
      sp_at_one = (sp_cur == SP_W'(1));
    end else begin
      sp_next   = {sp_cur[SP_W-1:NARROW_W], low_next};
      sp_addr   = {{HI_W{1'b0}}, low_next};
      sp_at_one = (sp_cur[NARROW_W-1:0] == NARROW_W'(1));
    end
  end
endmodule

// File: rtl/spu_payload.sv
module spu_payload
  import spu_pkg::*;
#(
  parameter int SP_W     = 32,
  parameter int NARROW_W = 16
) (
  input  src_kind_e         kind,
  input  logic [SP_W-1:0]   src_val,
  input  logic [SP_W-1:0]   sp_cur,
  input  logic              op_wide,
  output logic [SP_W-1:0]   data,
  output logic [SP_W/8-1:0] be
);
  localparam int LANES    = SP_W / 8;
  localparam int NARROW_B = NARROW_W / 8;

  logic [SP_W-1:0] raw;
  logic            is_seg;

  assign raw    = (kind == SRC_STACKPTR) ? sp_cur : src_val;
  assign is_seg = (kind == SRC_SEGSEL);

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic lane_on;
    logic lane_keep;
    if (gi < NARROW_B) begin : g_low
      assign lane_on   = 1'b1;
      assign lane_keep = 1'b1;
    end else begin : g_high
      assign lane_on   = op_wide;
      assign lane_keep = op_wide && !is_seg;
    end
    assign be[gi]          = lane_on;
    assign data[gi*8 +: 8] = lane_keep ? raw[gi*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/spu_ctrl.sv
module spu_ctrl
  import spu_pkg::*;
#(
  parameter int SP_W     = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt_cond,
  input  logic              stk_wide,
  input  logic [SP_W-1:0]   sp_cur,
  input  logic [SP_W-1:0]   sp_next,
  input  logic [SP_W-1:0]   sp_addr,
  input  logic [SP_W-1:0]   data,
  input  logic [SP_W/8-1:0] be,
  input  logic [SP_W-1:0]   ea_calc,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [SP_W-1:0]   wr_addr,
  output logic [SP_W-1:0]   wr_data,
  output logic [SP_W/8-1:0] wr_be,
  output logic [SP_W-1:0]   ea_addr,
  output logic [SP_W-1:0]   sp_out,
  output logic              done,
  output logic              busy,
  output logic              shutdown
);
  localparam int BE_W = SP_W / 8;

  ctrl_state_e       state_q;
  logic [SP_W-1:0]   addr_q, data_q, pend_q, out_q, ea_q, orig_q;
  logic [BE_W-1:0]   be_q;
  logic              done_q, wide_q;
  logic              accept, handshake;

  assign accept    = start && (state_q == ST_IDLE);
  assign handshake = (state_q == ST_WRITE) && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      pend_q  <= '0;
      out_q   <= '0;
      ea_q    <= '0;
      orig_q  <= '0;
      wide_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ea_q   <= ea_calc;
            orig_q <= sp_cur;
            wide_q <= stk_wide;
            if (halt_cond) begin
              state_q <= ST_HALT;
            end else begin
              state_q <= ST_WRITE;
              addr_q  <= sp_addr;
              data_q  <= data;
              be_q    <= be;
              pend_q  <= sp_next;
            end
          end
        end
        ST_WRITE: begin
          if (handshake) begin
            state_q <= ST_IDLE;
            out_q   <= pend_q;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign wr_valid = (state_q == ST_WRITE);
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign wr_be    = be_q;
  assign ea_addr  = ea_q;
  assign sp_out   = out_q;
  assign done     = done_q;
  assign busy     = (state_q != ST_IDLE);
  assign shutdown = (state_q == ST_HALT);

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!wr_valid && !done));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);

  assert_upper_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_q) |-> (sp_out[SP_W-1:NARROW_W] == orig_q[SP_W-1:NARROW_W]));

  assert_step_matches_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (NARROW_W'(orig_q - sp_out) == NARROW_W'($countones(wr_be))));
endmodule

// File: rtl/stack_push_unit.sv
module stack_push_unit
  import spu_pkg::*;
#(
  parameter int SP_W     = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [1:0]        src_kind,
  input  logic [SP_W-1:0]   src_val,
  input  logic              op_wide,
  input  logic              stk_wide,
  input  logic              real_mode,
  input  logic              ea_use_sp,
  input  logic [SP_W-1:0]   ea_base,
  input  logic [SP_W-1:0]   ea_disp,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [SP_W-1:0]   wr_addr,
  output logic [SP_W-1:0]   wr_data,
  output logic [SP_W/8-1:0] wr_be,
  output logic [SP_W-1:0]   ea_addr,
  output logic [SP_W-1:0]   sp_out,
  output logic              done,
  output logic              busy,
  output logic              shutdown
);
  localparam int BE_W = SP_W / 8;

  logic [SP_W-1:0] sp_next, sp_addr, pay_data, ea_calc;
  logic [BE_W-1:0] pay_be;
  logic            sp_at_one;

  assign ea_calc = (ea_use_sp ? sp_in : ea_base) + ea_disp;

  spu_sp_calc #(.SP_W(SP_W), .NARROW_W(NARROW_W)) u_sp_calc (
    .sp_cur    (sp_in),
    .op_wide   (op_wide),
    .stk_wide  (stk_wide),
    .sp_next   (sp_next),
    .sp_addr   (sp_addr),
    .sp_at_one (sp_at_one)
  );

  spu_payload #(.SP_W(SP_W), .NARROW_W(NARROW_W)) u_payload (
    .kind    (src_kind_e'(src_kind)),
    .src_val (src_val),
    .sp_cur  (sp_in),
    .op_wide (op_wide),
    .data    (pay_data),
    .be      (pay_be)
  );

  spu_ctrl #(.SP_W(SP_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .halt_cond (real_mode && sp_at_one),
    .stk_wide  (stk_wide),
    .sp_cur    (sp_in),
    .sp_next   (sp_next),
    .sp_addr   (sp_addr),
    .data      (pay_data),
    .be        (pay_be),
    .ea_calc   (ea_calc),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .ea_addr   (ea_addr),
    .sp_out    (sp_out),
    .done      (done),
    .busy      (busy),
    .shutdown  (shutdown)
  );

  assert_write_in_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !stk_wide && !(real_mode && sp_at_one)) |=> (wr_addr[SP_W-1:NARROW_W] == '0));
endmodule

// File: tb/stack_push_unit_tb.sv
`timescale 1ns/1ps
module stack_push_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] sp_in = '0;
  logic [1:0]  src_kind = '0;
  logic [31:0] src_val = '0;
  logic        op_wide = 1'b1, stk_wide = 1'b1, real_mode = 1'b0;
  logic        ea_use_sp = 1'b0;
  logic [31:0] ea_base = '0, ea_disp = '0;
  logic        wr_valid, wr_ready = 1'b1;
  logic [31:0] wr_addr, wr_data, ea_addr, sp_out;
  logic [3:0]  wr_be;
  logic        done, busy, shutdown;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  stack_push_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sp_in(sp_in), .src_kind(src_kind),
    .src_val(src_val), .op_wide(op_wide), .stk_wide(stk_wide), .real_mode(real_mode),
    .ea_use_sp(ea_use_sp), .ea_base(ea_base), .ea_disp(ea_disp),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .ea_addr(ea_addr), .sp_out(sp_out), .done(done), .busy(busy),
    .shutdown(shutdown)
  );

  typedef struct packed {
    logic [31:0] sp;
    logic [1:0]  kind;
    logic [31:0] val;
    logic        op32;
    logic        stk32;
    logic [31:0] exp_sp;
    logic [31:0] exp_data;
    logic [3:0]  exp_be;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 2'd0, 32'hDEAD_BEEF, 1'b1, 1'b1, 32'h0000_0FFC, 32'hDEAD_BEEF, 4'hF}, // R2
    '{32'h0000_1000, 2'd0, 32'hDEAD_BEEF, 1'b0, 1'b1, 32'h0000_0FFE, 32'h0000_BEEF, 4'h3}, // R3 R10
    '{32'h0000_0FFE, 2'd3, 32'h1234_5678, 1'b1, 1'b1, 32'h0000_0FFA, 32'h1234_5678, 4'hF}, // R10 R6
    '{32'hABCD_0000, 2'd0, 32'h1122_3344, 1'b1, 1'b0, 32'hABCD_FFFC, 32'h1122_3344, 4'hF}, // R4 wrap
    '{32'hABCD_0001, 2'd0, 32'h0000_CAFE, 1'b0, 1'b0, 32'hABCD_FFFF, 32'h0000_CAFE, 4'h3}, // R12
    '{32'h0000_2000, 2'd1, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_1FFC, 32'h0000_2000, 4'hF}, // R5
    '{32'h5555_8000, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h5555_7FFE, 32'h0000_8000, 4'h3}, // R5
    '{32'h0000_0100, 2'd2, 32'hFFFF_0023, 1'b1, 1'b1, 32'h0000_00FC, 32'h0000_0023, 4'hF}, // R6
    '{32'h0000_0100, 2'd2, 32'hABCD_0042, 1'b0, 1'b1, 32'h0000_00FE, 32'h0000_0042, 4'h3}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] sp, input logic [1:0] kind, input logic [31:0] val,
                        input logic op32, input logic stk32, input logic rm);
    @(negedge clk);
    sp_in = sp; src_kind = kind; src_val = val;
    op_wide = op32; stk_wide = stk32; real_mode = rm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wr_valid", {31'b0, wr_valid}, 32'd0);
    chk("R1 done/busy/shutdown", {29'b0, done, busy, shutdown}, 32'd0);
    chk("R1 sp_out", sp_out, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i].sp, VECS[i].kind, VECS[i].val, VECS[i].op32, VECS[i].stk32, 1'b0);
      chk($sformatf("R2/R4 vec%0d wr_addr", i), wr_addr,
          VECS[i].stk32 ? VECS[i].exp_sp : {16'h0, VECS[i].exp_sp[15:0]});
      chk($sformatf("R3/R5/R6 vec%0d wr_data", i), wr_data, VECS[i].exp_data);
      chk($sformatf("R3 vec%0d wr_be", i), {28'b0, wr_be}, {28'b0, VECS[i].exp_be});
      @(negedge clk);
      chk($sformatf("R8 vec%0d done", i), {31'b0, done}, 32'd1);
      chk($sformatf("R2/R4/R10 vec%0d sp_out", i), sp_out, VECS[i].exp_sp);
    end

    // R7: operand address from the pre-decrement pointer
    ea_use_sp = 1'b1; ea_disp = 32'd8;
    launch(32'h0000_3000, 2'd0, 32'h0, 1'b1, 1'b1, 1'b0);
    chk("R7 ea with sp base", ea_addr, 32'h0000_3008);
    @(negedge clk);
    ea_use_sp = 1'b0; ea_base = 32'h0000_0100; ea_disp = 32'd4;
    launch(32'h0000_3000, 2'd0, 32'h0, 1'b1, 1'b1, 1'b0);
    chk("R7 ea with other base", ea_addr, 32'h0000_0104);
    @(negedge clk);

    // R8 back-pressure, R11 start while busy
    wr_ready = 1'b0;
    launch(32'h0000_0400, 2'd0, 32'hA5A5_A5A5, 1'b1, 1'b1, 1'b0);
    sp_in = 32'h0000_9999; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R8 held valid", {31'b0, wr_valid}, 32'd1);
    chk("R8/R11 held addr", wr_addr, 32'h0000_03FC);
    chk("R8 no early done", {31'b0, done}, 32'd0);
    wr_ready = 1'b1;
    @(negedge clk);
    chk("R8 done after ack", {31'b0, done}, 32'd1);
    chk("R11 sp_out from first push", sp_out, 32'h0000_03FC);
    @(negedge clk);
    chk("R8 done single / R11 no second write", {30'b0, done, wr_valid}, 32'd0);

    // R9/R12: real mode, full pointer not 1 on 32-bit stack
    launch(32'h0001_0001, 2'd0, 32'h0000_7777, 1'b0, 1'b1, 1'b1);
    chk("R12 real mode no halt", {31'b0, shutdown}, 32'd0);
    @(negedge clk);
    chk("R12 real mode sp_out", sp_out, 32'h0000_FFFF);

    // R9: real mode, SP == 1 on 16-bit stack
    launch(32'h7777_0001, 2'd0, 32'h0000_1111, 1'b0, 1'b0, 1'b1);
    chk("R9 shutdown set", {31'b0, shutdown}, 32'd1);
    chk("R9 no write", {31'b0, wr_valid}, 32'd0);
    @(negedge clk);
    chk("R9 no done, sp_out kept", {sp_out[30:0], done}, {31'h0000_FFFF, 1'b0});
    launch(32'h0000_2000, 2'd0, 32'h0, 1'b1, 1'b1, 1'b0);
    chk("R9 start ignored when halted", {30'b0, wr_valid, shutdown}, 32'd1);

    // R1: reset releases shutdown
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears shutdown", {30'b0, shutdown, busy}, 32'd0);
    rst_n = 1'b1;

    // R9: real mode, ESP == 1 on 32-bit stack
    launch(32'h0000_0001, 2'd0, 32'h0, 1'b1, 1'b1, 1'b1);
    chk("R9 shutdown 32-bit stack", {30'b0, shutdown, wr_valid}, 32'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule